// File: doc/BRIEF.md
# Internal Data Address and Stack Unit

This block turns the operand of a data-memory access into a concrete 8-bit location for a small 8-bit microcontroller core. The decoder presents an addressing mode, an operand byte, the two register-bank select bits and the current contents of the two pointer registers R0 and R1. The block returns the resolved address and a flag that says whether the access goes to internal RAM or to the special-function-register (SFR) space.

The block also owns the hardware stack pointer. The stack sits in internal RAM and grows toward higher addresses. A push increments the pointer before the write, and a pop reads at the pointer before decrementing it. The pointer is also an SFR that software can read and write. The address and target outputs are combinational from the inputs and the current pointer. The pointer itself changes on the clock edge after a push, a pop or an SFR write.

Top module: `dstk_unit`

## Requirements
- R1: After synchronous reset the stack pointer holds 0x07.
- R2: Register mode (mode 0) resolves to bank*8 + operand[2:0], with the bank taken from bank_i, and targets RAM.
- R3: Direct mode (mode 1) passes the operand through as the address. Values 0x00–0x7F target RAM and values 0x80–0xFF target the SFR space.
- R4: Indirect mode (mode 2) uses R1 when operand bit 0 is 1 and R0 otherwise. Any value 0x00–0xFF is used as the address, and the access always targets RAM.
- R5: Push mode (mode 3) addresses RAM at pointer+1, and the pointer becomes pointer+1 after the clock edge. The first push after reset therefore lands at 0x08.
- R6: Pop mode (mode 4) addresses RAM at the current pointer, and the pointer becomes pointer−1 after the clock edge.
- R7: The pointer wraps modulo 256. A push at 0xFF addresses 0x00 and leaves 0x00, and a pop at 0x00 leaves 0xFF.
- R8: An SFR write to address 0x81 loads the pointer on the next edge. It takes priority over a push or pop in the same cycle, although that access still uses the old pointer for its address.
- R9: SFR read data is the pointer when sfr_addr_i is 0x81 and 0 otherwise. SFR writes to any other address leave the pointer unchanged.
- R10: Mode codes 5–7 resolve to address 0x00 targeting RAM, and they leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Addressing mode: 0 reg, 1 direct, 2 indirect, 3 push, 4 pop |
| opnd_i | input | 8 | Operand byte |
| bank_i | input | 2 | Register-bank select |
| r0_i | input | 8 | Current R0 contents |
| r1_i | input | 8 | Current R1 contents |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address for read and write |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data |
| addr_o | output | 8 | Resolved data address |
| sfr_sel_o | output | 1 | 1 = SFR space, 0 = internal RAM |
| sp_o | output | 8 | Current stack pointer |

## Verification
The address, target flag and SFR read data are combinational, so they are due in the same cycle the inputs are applied. The bench drives each stimulus after a falling edge and compares these outputs one time unit later. The pointer changes one edge after a push, pop or SFR write. The bench therefore updates its model at the rising edge and compares sp_o at the next sampling point, one cycle after the stimulus. Random traffic is combined with directed cases for wrap, write priority, other SFR addresses and the reserved mode codes.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned BANK_W   = 2;
    localparam int unsigned RIDX_W   = 3;
    localparam int unsigned MODE_W   = 3;
    localparam logic [DATA_W-1:0] SP_RESET    = 8'h07;
    localparam logic [DATA_W-1:0] SP_SFR_ADDR = 8'h81;

    typedef enum logic [MODE_W-1:0] {
        AM_REG  = 3'd0,
        AM_DIR  = 3'd1,
        AM_IND  = 3'd2,
        AM_PUSH = 3'd3,
        AM_POP  = 3'd4
    } amode_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              sfr;
    } dres_t;

    typedef struct packed {
        logic              push;
        logic              pop;
        logic              load;
        logic [DATA_W-1:0] wdata;
    } sp_ctl_t;

    function automatic logic [DATA_W-1:0] bank_reg_addr(
        input logic [BANK_W-1:0] bank, input logic [RIDX_W-1:0] idx);
        return {{(DATA_W-BANK_W-RIDX_W){1'b0}}, bank, idx};
    endfunction

    function automatic logic direct_is_sfr(input logic [DATA_W-1:0] a);
        return a[DATA_W-1];
    endfunction
endpackage

// File: rtl/dstk_resolve.sv
module dstk_resolve
    import dstk_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] opnd,
    input  logic [BANK_W-1:0] bank,
    input  logic [DATA_W-1:0] r0,
    input  logic [DATA_W-1:0] r1,
    input  logic [DATA_W-1:0] sp,
    output dres_t             res
);
    logic [DATA_W-1:0] ptr;

    always_comb begin
        ptr = opnd[0] ? r1 : r0;
        res = '0;
        case (mode)
            AM_REG:  res.addr = bank_reg_addr(bank, opnd[RIDX_W-1:0]);
            AM_DIR: begin
                res.addr = opnd;
                res.sfr  = direct_is_sfr(opnd);
            end
            AM_IND:  res.addr = ptr;
            AM_PUSH: res.addr = sp + 1'b1;
            AM_POP:  res.addr = sp;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/dstk_sp.sv
module dstk_sp
    import dstk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sp_ctl_t           ctl,
    output logic [DATA_W-1:0] sp
);
    always_ff @(posedge clk) begin
        if (rst)           sp <= SP_RESET;
        else if (ctl.load) sp <= ctl.wdata;
        else if (ctl.push) sp <= sp + 1'b1;
        else if (ctl.pop)  sp <= sp - 1'b1;
    end
endmodule

// File: rtl/dstk_unit.sv
module dstk_unit
    import dstk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode_i,
    input  logic [7:0]  opnd_i,
    input  logic [1:0]  bank_i,
    input  logic [7:0]  r0_i,
    input  logic [7:0]  r1_i,
    input  logic        sfr_we_i,
    input  logic [7:0]  sfr_addr_i,
    input  logic [7:0]  sfr_wdata_i,
    output logic [7:0]  sfr_rdata_o,
    output logic [7:0]  addr_o,
    output logic        sfr_sel_o,
    output logic [7:0]  sp_o
);
    dres_t             res;
    sp_ctl_t           ctl;
    logic [DATA_W-1:0] sp;
    logic              sp_hit;

    assign sp_hit    = (sfr_addr_i == SP_SFR_ADDR);
    assign ctl.push  = (mode_i == AM_PUSH);
    assign ctl.pop   = (mode_i == AM_POP);
    assign ctl.load  = sfr_we_i && sp_hit;
    assign ctl.wdata = sfr_wdata_i;

    dstk_resolve u_res (
        .mode (mode_i),
        .opnd (opnd_i),
        .bank (bank_i),
        .r0   (r0_i),
        .r1   (r1_i),
        .sp   (sp),
        .res  (res)
    );

    dstk_sp u_sp (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .sp  (sp)
    );

    assign addr_o      = res.addr;
    assign sfr_sel_o   = res.sfr;
    assign sp_o        = sp;
    assign sfr_rdata_o = sp_hit ? sp : '0;
endmodule

// File: rtl/dstk_unit_chk.sv
module dstk_unit_chk
    import dstk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_i,
    input logic [7:0] opnd_i,
    input logic       sfr_we_i,
    input logic [7:0] sfr_addr_i,
    input logic [7:0] sfr_wdata_i,
    input logic       sfr_sel_o,
    input logic [7:0] sp_o
);
    logic wr_sp;
    assign wr_sp = sfr_we_i && (sfr_addr_i == SP_SFR_ADDR);

    AST_RESET_VAL: assert property (@(posedge clk) rst |=> sp_o == SP_RESET); // R1
    AST_DIRECT_SPLIT: assert property (@(posedge clk) disable iff (rst)
        mode_i == AM_DIR |-> sfr_sel_o == opnd_i[7]); // R3
    AST_INDIR_RAM: assert property (@(posedge clk) disable iff (rst)
        mode_i == AM_IND |-> !sfr_sel_o); // R4
    AST_PUSH_INC: assert property (@(posedge clk) disable iff (rst)
        (mode_i == AM_PUSH && !wr_sp) |=> sp_o == $past(sp_o) + 8'd1); // R5
    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (mode_i == AM_POP && !wr_sp) |=> sp_o == $past(sp_o) - 8'd1); // R6
    AST_SFR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_sp |=> sp_o == $past(sfr_wdata_i)); // R8
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i > 3'd4 && !wr_sp) |=> $stable(sp_o)); // R10
endmodule

bind dstk_unit dstk_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .opnd_i      (opnd_i),
    .sfr_we_i    (sfr_we_i),
    .sfr_addr_i  (sfr_addr_i),
    .sfr_wdata_i (sfr_wdata_i),
    .sfr_sel_o   (sfr_sel_o),
    .sp_o        (sp_o)
);

// File: tb/dstk_unit_test.sv
`timescale 1ns/1ps
module dstk_unit_test;
    logic       clk = 0;
    logic       rst = 1;
    logic [2:0] mode_i = 0;
    logic [7:0] opnd_i = 0, r0_i = 0, r1_i = 0;
    logic [1:0] bank_i = 0;
    logic       sfr_we_i = 0;
    logic [7:0] sfr_addr_i = 0, sfr_wdata_i = 0;
    logic [7:0] sfr_rdata_o, addr_o, sp_o;
    logic       sfr_sel_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m_sp;

    always #5 clk = ~clk;

    dstk_unit uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_res(input logic [2:0] m, input logic [7:0] op,
        input logic [1:0] bk, input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] sp);
        case (m)
            3'd0: return {1'b0, 3'b000, bk, op[2:0]};
            3'd1: return {op[7], op};
            3'd2: return {1'b0, op[0] ? a1 : a0};
            3'd3: return {1'b0, sp + 8'd1};
            3'd4: return {1'b0, sp};
            default: return 9'h000;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R10";
        endcase
    endfunction

    // one cycle: apply at negedge, check combinational at +1, model SP at edge
    task automatic step(input logic [2:0] m, input logic [7:0] op, input logic [1:0] bk,
                        input logic [7:0] a0, input logic [7:0] a1, input logic we,
                        input logic [7:0] sa, input logic [7:0] wd);
        logic [8:0] e;
        mode_i = m; opnd_i = op; bank_i = bk; r0_i = a0; r1_i = a1;
        sfr_we_i = we; sfr_addr_i = sa; sfr_wdata_i = wd;
        #1;
        e = exp_res(m, op, bk, a0, a1, m_sp);
        chk(req_of(m), {sfr_sel_o, addr_o}, e);
        chk("R9", sfr_rdata_o, (sa == 8'h81) ? m_sp : 8'h00);
        @(posedge clk);
        if (we && sa == 8'h81) m_sp = wd;
        else if (m == 3'd3) m_sp = m_sp + 8'd1;
        else if (m == 3'd4) m_sp = m_sp - 8'd1;
        @(negedge clk);
        #1;
        chk("R8", sp_o, m_sp);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] m;
        logic [7:0] sa;
        repeat (3) @(negedge clk);
        rst = 0;
        m_sp = 8'h07;
        #1;
        chk("R1", sp_o, 8'h07);
        // first push after reset
        step(3'd3, 8'h00, 2'd0, 8'h0, 8'h0, 1'b0, 8'h81, 8'h0);
        chk("R5", sp_o, 8'h08);
        step(3'd4, 8'h00, 2'd0, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        chk("R6", sp_o, 8'h07);
        // register bank 3, R7
        step(3'd0, 8'h07, 2'd3, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        // direct boundary
        step(3'd1, 8'h7F, 2'd0, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        step(3'd1, 8'h80, 2'd0, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        // indirect upper RAM via R1 and R0
        step(3'd2, 8'h01, 2'd0, 8'h12, 8'hC0, 1'b0, 8'h00, 8'h0);
        step(3'd2, 8'hFE, 2'd0, 8'hFF, 8'h34, 1'b0, 8'h00, 8'h0);
        // wrap up and down
        step(3'd5, 8'h00, 2'd0, 8'h0, 8'h0, 1'b1, 8'h81, 8'hFF);
        step(3'd3, 8'h00, 2'd0, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        chk("R7", sp_o, 8'h00);
        step(3'd4, 8'h00, 2'd0, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        chk("R7", sp_o, 8'hFF);
        // write priority over push
        step(3'd3, 8'h00, 2'd0, 8'h0, 8'h0, 1'b1, 8'h81, 8'h40);
        chk("R8", sp_o, 8'h40);
        // write to other SFR ignored
        step(3'd6, 8'h00, 2'd0, 8'h0, 8'h0, 1'b1, 8'h80, 8'h99);
        chk("R9", sp_o, 8'h40);
        // reserved mode holds
        step(3'd7, 8'hAA, 2'd2, 8'h0, 8'h0, 1'b0, 8'h00, 8'h0);
        chk("R10", sp_o, 8'h40);
        // random traffic
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            m  = 3'($urandom_range(0, 7));
            sa = ($urandom_range(0, 1) == 1) ? 8'h81 : 8'($urandom);
            step(m, 8'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
                 ($urandom_range(0, 7) == 0), sa, 8'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule